// File: doc/BRIEF.md
# Slippable PN Spreading Code Generator

This block produces a pseudorandom chip stream from a maximal-length linear feedback shift register. It runs in its own code-clock domain, and each output chip is synchronous with that clock. One instance drives transmit spreading and a second drives receive despreading. With the default 6-bit register the sequence repeats every 63 chips.

The receive instance can be moved in phase against a remote transmitter. While the slip-enable input is high, an accepted slip request stops the register from advancing for one code-clock edge. The local code then falls one chip behind its previous alignment. While slip-enable is low, slip requests have no effect.

The all-zero register state is a lockup state and is never part of the sequence. The register leaves reset in that state. On the next edge a one is forced into the feedback so that the sequence starts. A marker output goes high once per period, at a fixed register state, so that a test fixture can align to the sequence.

Top module: `pn_code_gen`

## Requirements
- R1: While rst_n is low, the register is all zeros, chip is 0 and epoch is 0.
- R2: When the register holds all zeros, the next clock edge loads the value 000001. No extra cycle is spent, and the first edge after reset release does this.
- R3: On an advancing edge, a nonzero register s becomes {s[4:0], s[5] XOR s[4]}, which is the polynomial x^6 + x^5 + 1. The chip output always shows register bit 5, the most significant bit.
- R4: With no slips, the register returns to any given nonzero state after exactly 63 advances, and epoch rises once every 63 cycles.
- R5: With slip_en high, a slip_req that is high at a clock edge is one accepted slip in the default level mode. That edge does not change the register, so chip and epoch keep their values for one more cycle.
- R6: While slip_en is low, slip_req has no effect and the register advances on every edge.
- R7: Lockup recovery has priority over slipping. A slip request that is accepted while the register is all zeros does not delay the load of 000001.
- R8: epoch is 1 exactly when the register holds 111111, and 0 otherwise.
- R9: A slip that is accepted while epoch is high keeps epoch high for one more cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Code clock. |
| rst_n | input | 1 | Asynchronous active-low reset. |
| slip_en | input | 1 | Permits slips while high. |
| slip_req | input | 1 | Slip request. In level mode, each cycle it is high counts as one request. |
| chip | output | 1 | Current PN chip. |
| epoch | output | 1 | High while the register is at the marker state. |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is lockup recovery and a slip. The bench drives slip_en and slip_req high through reset release. It then expects the first chips to follow the 000001 start state with no held cycle.

The second pair is the period marker and a slip. The bench steps a reference model to the marker state and drives a slip on that edge. It then expects epoch to stay high for two samples.

Random slip patterns, with slip_en both enabled and disabled, are compared chip by chip with the reference model.

// File: rtl/pn_code_pkg.sv
package pn_code_pkg;

   typedef enum logic [0:0] {
      SLIP_LEVEL = 1'b0,
      SLIP_EDGE  = 1'b1
   } slip_mode_e;

   localparam int MIN_WIDTH = 2;
   localparam int MAX_WIDTH = 24;

   function automatic int seq_period(input int width);
      return (1 << width) - 1;
   endfunction

endpackage

// File: rtl/pn_slip_gate.sv
module pn_slip_gate
   import pn_code_pkg::*;
#(
   parameter slip_mode_e SLIP_MODE = SLIP_LEVEL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slip_en,
   input  logic slip_req,
   input  logic lockup,
   output logic hold
);

   logic take;

   generate
      if (SLIP_MODE == SLIP_EDGE) begin : g_edge
         logic req_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= slip_req;
         end
         assign take = slip_en & slip_req & ~req_q;
      end else begin : g_level
         assign take = slip_en & slip_req;
      end
   endgenerate

   assign hold = take & ~lockup;

endmodule

// File: rtl/pn_lfsr_core.sv
module pn_lfsr_core #(
   parameter int                 WIDTH    = 6,
   parameter logic [WIDTH-1:0]   TAP_MASK = 6'b110000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   output logic [WIDTH-1:0] state,
   output logic             lockup
);

   logic             fb;
   logic [WIDTH-1:0] state_d;

   assign lockup  = (state == '0);
   assign fb      = lockup | (^(state & TAP_MASK));
   assign state_d = hold ? state : {state[WIDTH-2:0], fb};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= '0;
      else        state <= state_d;
   end

endmodule

// File: rtl/pn_epoch_mark.sv
module pn_epoch_mark #(
   parameter int               WIDTH      = 6,
   parameter logic [WIDTH-1:0] MARK_STATE = '1
) (
   input  logic [WIDTH-1:0] state,
   output logic             mark
);

   assign mark = (state == MARK_STATE);

endmodule

// File: rtl/pn_code_gen.sv
module pn_code_gen
   import pn_code_pkg::*;
#(
   parameter int               WIDTH      = 6,
   parameter logic [WIDTH-1:0] TAP_MASK   = 6'b110000,
   parameter logic [WIDTH-1:0] MARK_STATE = '1,
   parameter slip_mode_e       SLIP_MODE  = SLIP_LEVEL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slip_en,
   input  logic slip_req,
   output logic chip,
   output logic epoch
);

   generate
      if (WIDTH < MIN_WIDTH || WIDTH > MAX_WIDTH) begin : g_bad_width
         $error("pn_code_gen: WIDTH out of range");
      end
      if (!TAP_MASK[WIDTH-1]) begin : g_bad_taps
         $error("pn_code_gen: top tap must be set");
      end
      if (MARK_STATE == '0) begin : g_bad_mark
         $error("pn_code_gen: marker cannot be the lockup state");
      end
   endgenerate

   logic [WIDTH-1:0] lfsr_q;
   logic             lockup;
   logic             hold;

   pn_slip_gate #(.SLIP_MODE(SLIP_MODE)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .slip_en  (slip_en),
      .slip_req (slip_req),
      .lockup   (lockup),
      .hold     (hold)
   );

   pn_lfsr_core #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold   (hold),
      .state  (lfsr_q),
      .lockup (lockup)
   );

   pn_epoch_mark #(.WIDTH(WIDTH), .MARK_STATE(MARK_STATE)) u_mark (
      .state (lfsr_q),
      .mark  (epoch)
   );

   assign chip = lfsr_q[WIDTH-1];

endmodule

// File: rtl/pn_code_gen_chk.sv
module pn_code_gen_chk
   import pn_code_pkg::*;
#(
   parameter int               WIDTH      = 6,
   parameter logic [WIDTH-1:0] TAP_MASK   = 6'b110000,
   parameter logic [WIDTH-1:0] MARK_STATE = '1,
   parameter slip_mode_e       SLIP_MODE  = SLIP_LEVEL
) (
   input logic             clk,
   input logic             rst_n,
   input logic             slip_en,
   input logic             slip_req,
   input logic [WIDTH-1:0] state,
   input logic             epoch
);

   localparam int PERIOD = seq_period(WIDTH);

   logic             req_prev;
   logic             accepted;
   logic [WIDTH-1:0] prev_state;
   logic [WIDTH:0]   adv_cnt;
   logic             seen_mark;
   logic             enter_mark;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_prev <= 1'b0;
      else        req_prev <= slip_req;
   end

   assign accepted   = slip_en & slip_req & ((SLIP_MODE == SLIP_LEVEL) | ~req_prev);
   assign enter_mark = (state == MARK_STATE) && (prev_state != MARK_STATE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_state <= '0;
         adv_cnt    <= '0;
         seen_mark  <= 1'b0;
      end else begin
         prev_state <= state;
         if (enter_mark) begin
            adv_cnt   <= '0;
            seen_mark <= 1'b1;
         end else if (state != prev_state) begin
            adv_cnt <= adv_cnt + 1'b1;
         end
      end
   end

   AST_LOCKUP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == '0) |=> (state == WIDTH'(1)));                        // R2

   AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!accepted && state != '0) |=>
         (state[WIDTH-1:1] == $past(state[WIDTH-2:0]) &&
          state[0] == $past(^(state & TAP_MASK))));                   // R3

   AST_PERIOD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_mark && enter_mark) |-> (adv_cnt == (WIDTH+1)'(PERIOD-1))); // R4

   AST_SLIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (accepted && state != '0) |=> $stable(state));                  // R5

   AST_NO_SLIP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!slip_en) |=> (state != $past(state)));                        // R6

   AST_RECOVER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (accepted && state == '0) |=> (state != '0));                   // R7

   AST_EPOCH_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (epoch && accepted) |=> epoch);                                 // R9

endmodule

bind pn_code_gen pn_code_gen_chk #(
   .WIDTH      (WIDTH),
   .TAP_MASK   (TAP_MASK),
   .MARK_STATE (MARK_STATE),
   .SLIP_MODE  (SLIP_MODE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .slip_en  (slip_en),
   .slip_req (slip_req),
   .state    (lfsr_q),
   .epoch    (epoch)
);

// File: tb/tb_pn_code_gen.sv
`timescale 1ns/1ps
module tb_pn_code_gen;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic slip_en = 1'b0;
   logic slip_req = 1'b0;
   logic chip;
   logic epoch;

   int checks = 0;
   int errors = 0;
   logic [5:0] m = '0;   // reference register

   int last_epoch = -1;
   int cyc_no = 0;
   logic ep_prev = 1'b0;
   bit period_track = 1'b0;

   always #10 clk = ~clk;

   pn_code_gen dut (
      .clk(clk), .rst_n(rst_n), .slip_en(slip_en), .slip_req(slip_req),
      .chip(chip), .epoch(epoch)
   );

   function automatic logic [5:0] ref_next(input logic [5:0] s);
      if (s == 6'd0) return 6'd1;
      return {s[4:0], s[5] ^ s[4]};
   endfunction

   task automatic check_bit(input string tag, input logic got, input logic exp, input string what);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s got %0b exp %0b (cycle %0d)", tag, what, got, exp, cyc_no);
      end
   endtask

   task automatic step(input bit en, input bit req, input string tag);
      check_bit(tag, chip, m[5], "chip");
      check_bit(tag, epoch, (m == 6'h3F), "epoch");
      if (period_track && epoch && !ep_prev) begin
         if (last_epoch >= 0) begin
            checks++;
            if (cyc_no - last_epoch != 63) begin
               errors++;
               $display("FAIL R4 epoch spacing got %0d exp 63", cyc_no - last_epoch);
            end
         end
         last_epoch = cyc_no;
      end
      ep_prev = epoch;
      slip_en  = en;
      slip_req = req;
      if (!(en && req) || m == 6'd0) m = ref_next(m);
      cyc_no++;
      @(negedge clk);
   endtask

   task automatic do_reset(input bit en, input bit req);
      rst_n = 1'b0;
      slip_en = en;
      slip_req = req;
      repeat (3) @(negedge clk);
      check_bit("R1", chip, 1'b0, "chip in reset");
      check_bit("R1", epoch, 1'b0, "epoch in reset");
      m = '0;
      rst_n = 1'b1;
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      do_reset(1'b0, 1'b0);

      // R2/R3: start-up sequence and free run, R8 marker, R4 spacing
      period_track = 1'b1;
      for (int i = 0; i < 200; i++) step(1'b0, 1'b0, "R3");
      period_track = 1'b0;

      // R6: slip requests while disabled
      for (int i = 0; i < 150; i++) step(1'b0, 1'($urandom_range(0, 1)), "R6");

      // R5: random accepted slips
      for (int i = 0; i < 300; i++) step(1'b1, 1'($urandom_range(0, 3) == 0), "R5");

      // R9: slip exactly while the marker is up
      while (m != 6'h3F) step(1'b0, 1'b0, "R8");
      step(1'b1, 1'b1, "R9");
      check_bit("R9", epoch, 1'b1, "epoch stretched");
      step(1'b0, 1'b0, "R9");
      step(1'b0, 1'b0, "R8");

      // R7: slip held through reset release, recovery must not wait
      do_reset(1'b1, 1'b1);
      step(1'b1, 1'b1, "R7");
      for (int i = 0; i < 8; i++) step(1'b1, 1'b1, "R7");
      for (int i = 0; i < 20; i++) step(1'b0, 1'b0, "R2");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule